// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block turns the requests of an 8-bit controller core into strobe and address traffic on a multiplexed external memory bus. It counts oscillator periods with a twelve-step phase counter, and each full turn of the counter is one machine cycle. Within a machine cycle it raises an address latch enable (`ale`) pulse, drops a program-store read strobe (`psen_n`) while code is fetched from outside, and, when the core asks for a data-memory transfer, drops either the data read strobe (`rd_n`) or the data write strobe (`wr_n`).

The low address byte and the data byte share the 8-bit port `p0`. The high byte goes out on `p2`. The core supplies a fetch address, a data request (read or write, with a flag that chooses a 16-bit or an 8-bit address), write data, and the value of its high-port register. It gets back fetched code bytes and read data, each with a one-period valid pulse, and a done pulse when a data transfer ends.

A small state machine picks the type of each machine cycle. It has three states: `CYC_FETCH` (two fetch slots), `CYC_READ` and `CYC_WRITE` (one data transfer). The type can change only when the phase counter is on its last step. At that point, every state takes one of three transitions. With no request pending it goes to `CYC_FETCH` (*idle-to-fetch*). With a pending write request it goes to `CYC_WRITE` (*request-write*). With a pending read request it goes to `CYC_READ` (*request-read*).

Top module: `xbus_seq`

## Requirements
- R1: While reset is held, and until the first clock edge after it is released, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `p0_oe`=0, and `fetch_valid`, `rd_valid` and `dm_done` are 0. The first machine cycle starts at phase 0 on the first edge after release.
- R2: In a fetch cycle, `ale` is high in phases 0–1 and 6–7. It therefore repeats every 6 periods and stays high for 2 periods.
- R3: In a fetch cycle with `ext_code`=1, `psen_n` is low in phases 3–5 and 9–11. It falls 1 period after `ale` falls, stays low for 3 periods, and is low twice per machine cycle.
- R4: `dm_req` is sampled only in phase 11. A pending request makes the next machine cycle a data cycle. In a data cycle `ale` is high only in phases 0–1, and `psen_n` stays high for the whole cycle.
- R5: In a read cycle `rd_n` is low in phases 5–10, and in a write cycle `wr_n` is low in the same phases. That is 3 periods after `ale` falls and 6 periods long. `ale` rises 1 period after the strobe rises.
- R6: `p2_out` carries `fetch_addr[15:8]` in an external fetch slot. In a data cycle it carries `dm_addr[15:8]` when `dm_wide`=1, and `p2_reg` when `dm_wide`=0.
- R7: `p0` drives the low address byte from the rise of `ale` until 1 period after `ale` falls (phases 0–2 of a fetch slot). It floats while `psen_n` is low. In a read cycle it drives the address in phases 0–4 and floats in phases 5–11, from the fall of `rd_n` onward.
- R8: In a write cycle `p0` drives the address in phases 0–2 and `dm_wdata` in phases 3–11. The data is therefore held 1 period after `wr_n` rises.
- R9: The byte on `p0_in` during the last low period of `rd_n` (phase 10) is returned on `rd_data`, with `rd_valid`=1 in phase 11. `dm_done`=1 in phase 11 of every data cycle.
- R10: The byte on `p0_in` during the last low period of each `psen_n` strobe is returned on `fetch_data`, with `fetch_valid`=1 in the following period (phase 6 or the next phase 0).
- R11: A fetch cycle with `ext_code`=0 keeps `psen_n` high and `p0` floating, raises no `fetch_valid`, and shows `p2_reg` on `p2_out`.
- R12: No two of `ale`, `psen_n` low, `rd_n` low and `wr_n` low are active in the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per phase |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_code | input | 1 | 1: code is fetched from external memory |
| fetch_addr | input | 16 | Code address for the next fetch slot |
| dm_req | input | 1 | Data-memory transfer pending |
| dm_wr | input | 1 | 1: write, 0: read |
| dm_wide | input | 1 | 1: 16-bit data address, 0: 8-bit |
| dm_addr | input | 16 | Data-memory address |
| dm_wdata | input | 8 | Write data |
| p2_reg | input | 8 | High-port register value |
| p0_in | input | 8 | Byte read back from the shared port |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Value driven on the shared port |
| p0_oe | output | 1 | Shared-port drive enable |
| p2_out | output | 8 | High port value |
| fetch_data | output | 8 | Fetched code byte |
| fetch_valid | output | 1 | One-period pulse when `fetch_data` is new |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | One-period pulse when `rd_data` is new |
| dm_done | output | 1 | One-period pulse at the end of a data cycle |

## Verification
Some properties are checked by assertions on every cycle: strobe exclusion, the 2-period `ale` width, the 1-period gap between the fall of `ale` and the fall of `psen_n`, the rise of `ale` right after a data strobe, bus release while `rd_n` is low, and write data held across the rise of `wr_n`. Other behaviour only the bench scenarios can show. That covers which address or register byte appears on each port in each phase, the choice between the 8-bit and 16-bit high byte, capture of the correct `p0_in` byte, suppression of fetch strobes when `ext_code`=0, and back-to-back data cycles. The bench checks these against a phase-by-phase expected-value model.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int CYC_LEN  = 12;
    localparam int HALF     = CYC_LEN / 2;
    localparam int ALE_LEN  = 2;
    localparam int PS_GAP   = 1;
    localparam int PS_LEN   = 3;
    localparam int DS_GAP   = 3;
    localparam int DS_LEN   = 6;
    localparam int PS_START = ALE_LEN + PS_GAP;
    localparam int PS_END   = PS_START + PS_LEN - 1;
    localparam int DS_START = ALE_LEN + DS_GAP;
    localparam int DS_END   = DS_START + DS_LEN - 1;
    localparam int WD_START = ALE_LEN + 1;
    localparam int PH_W     = $clog2(CYC_LEN);

    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
    import xbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph,
    output logic [PH_W-1:0] ph_nx,
    output logic            last
);
    always_comb begin
        last  = (ph == PH_W'(CYC_LEN - 1));
        ph_nx = last ? '0 : ph + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_W'(CYC_LEN - 1);
        else        ph <= ph_nx;
    end

    // R2: phase never leaves the machine-cycle range
    p_ph_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph < PH_W'(CYC_LEN));
endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm
    import xbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last,
    input  logic              dm_req,
    input  logic              dm_wr,
    input  logic [DATA_W-1:0] dm_wdata,
    output cyc_kind_e         st_nx,
    output logic [DATA_W-1:0] wd_q
);
    cyc_kind_e st;

    always_comb begin
        st_nx = st;
        if (last) begin
            unique case (st)
                CYC_FETCH, CYC_READ, CYC_WRITE: begin
                    if (!dm_req)    st_nx = CYC_FETCH;
                    else if (dm_wr) st_nx = CYC_WRITE;
                    else            st_nx = CYC_READ;
                end
                default: st_nx = CYC_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CYC_FETCH;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 wd_q <= '0;
        else if (last && dm_req)    wd_q <= dm_wdata;
    end

    // R4: the cycle type only changes across a machine-cycle boundary
    p_kind_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(st));
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] ph_nx,
    input  cyc_kind_e       st_nx,
    input  logic            ext_code,
    output logic            ale,
    output logic            psen_n,
    output logic            rd_n,
    output logic            wr_n
);
    logic [PH_W-1:0] lp;
    logic            ale_nx, psen_n_nx, rd_n_nx, wr_n_nx, ds_win;

    always_comb begin
        lp        = (ph_nx >= PH_W'(HALF)) ? ph_nx - PH_W'(HALF) : ph_nx;
        ds_win    = (ph_nx >= PH_W'(DS_START)) && (ph_nx <= PH_W'(DS_END));
        ale_nx    = (ph_nx < PH_W'(ALE_LEN)) ||
                    ((st_nx == CYC_FETCH) && (lp < PH_W'(ALE_LEN)));
        psen_n_nx = !((st_nx == CYC_FETCH) && ext_code &&
                      (lp >= PH_W'(PS_START)) && (lp <= PH_W'(PS_END)));
        rd_n_nx   = !((st_nx == CYC_READ) && ds_win);
        wr_n_nx   = !((st_nx == CYC_WRITE) && ds_win);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale    <= 1'b0;
            psen_n <= 1'b1;
            rd_n   <= 1'b1;
            wr_n   <= 1'b1;
        end else begin
            ale    <= ale_nx;
            psen_n <= psen_n_nx;
            rd_n   <= rd_n_nx;
            wr_n   <= wr_n_nx;
        end
    end

    // R2: a latch pulse lasts exactly two periods
    p_ale_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale ##1 !ale);
    // R3: program strobe falls one period after the latch pulse falls
    p_psen_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |-> (!$past(ale) && $past(ale, 2)));
    // R5: latch pulse follows a data strobe rise by one period
    p_ale_after_ds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |=> $rose(ale));
    // R12: strobes never overlap
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ale, !psen_n, !rd_n, !wr_n}) <= 1);
endmodule

// File: rtl/xbus_port_mux.sv
module xbus_port_mux
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   ph_nx,
    input  cyc_kind_e         st_nx,
    input  logic              ext_code,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] dm_addr,
    input  logic              dm_wide,
    input  logic [DATA_W-1:0] p2_reg,
    input  logic [DATA_W-1:0] wd_q,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [PH_W-1:0] lp;
    logic            oe_nx;

    always_comb begin
        lp = (ph_nx >= PH_W'(HALF)) ? ph_nx - PH_W'(HALF) : ph_nx;
        unique case (st_nx)
            CYC_FETCH: oe_nx = ext_code && (lp < PH_W'(PS_START));
            CYC_READ:  oe_nx = (ph_nx < PH_W'(DS_START));
            CYC_WRITE: oe_nx = 1'b1;
            default:   oe_nx = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p0_out <= '0;
            p0_oe  <= 1'b0;
            p2_out <= '0;
        end else begin
            p0_oe <= oe_nx;
            if ((st_nx == CYC_FETCH) && (lp == '0)) begin
                p0_out <= fetch_addr[DATA_W-1:0];
                p2_out <= ext_code ? DATA_W'(fetch_addr[ADDR_W-1 -: HI_W]) : p2_reg;
            end else if ((st_nx != CYC_FETCH) && (ph_nx == '0)) begin
                p0_out <= dm_addr[DATA_W-1:0];
                p2_out <= dm_wide ? DATA_W'(dm_addr[ADDR_W-1 -: HI_W]) : p2_reg;
            end else if ((st_nx == CYC_WRITE) && (ph_nx == PH_W'(WD_START))) begin
                p0_out <= wd_q;
            end
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_code,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              dm_req,
    input  logic              dm_wr,
    input  logic              dm_wide,
    input  logic [ADDR_W-1:0] dm_addr,
    input  logic [DATA_W-1:0] dm_wdata,
    input  logic [DATA_W-1:0] p2_reg,
    input  logic [DATA_W-1:0] p0_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic [DATA_W-1:0] fetch_data,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              dm_done
);
    logic [PH_W-1:0]   ph, ph_nx;
    logic              last;
    cyc_kind_e         st_nx;
    logic [DATA_W-1:0] wd_q;
    logic              f_take, r_take, d_end;

    xbus_phase_ctr u_ph (
        .clk(clk), .rst_n(rst_n), .ph(ph), .ph_nx(ph_nx), .last(last)
    );

    xbus_cycle_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .last(last), .dm_req(dm_req), .dm_wr(dm_wr),
        .dm_wdata(dm_wdata), .st_nx(st_nx), .wd_q(wd_q)
    );

    xbus_strobe_gen u_stb (
        .clk(clk), .rst_n(rst_n), .ph_nx(ph_nx), .st_nx(st_nx), .ext_code(ext_code),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    xbus_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .ph_nx(ph_nx), .st_nx(st_nx), .ext_code(ext_code),
        .fetch_addr(fetch_addr), .dm_addr(dm_addr), .dm_wide(dm_wide), .p2_reg(p2_reg),
        .wd_q(wd_q), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out)
    );

    // capture at the last low period of a strobe (its rising edge)
    always_comb begin
        f_take = !psen_n && ((ph == PH_W'(PS_END)) || (ph == PH_W'(HALF + PS_END)));
        r_take = !rd_n && (ph == PH_W'(DS_END));
        d_end  = (!rd_n || !wr_n) && (ph == PH_W'(DS_END));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_data  <= '0;
            fetch_valid <= 1'b0;
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            dm_done     <= 1'b0;
        end else begin
            fetch_valid <= f_take;
            rd_valid    <= r_take;
            dm_done     <= d_end;
            if (f_take) fetch_data <= p0_in;
            if (r_take) rd_data    <= p0_in;
        end
    end

    // R7: shared port released while the read strobe is low
    p_rd_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !p0_oe);
    // R8: write data driven while the write strobe is low and held past its rise
    p_wr_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> p0_oe);
    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (p0_oe && $stable(p0_out)));
    // R10: a fetched byte follows a program strobe period
    p_fetch_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ($past(!psen_n) && psen_n));
    // R9: done marks the end of a data strobe
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dm_done |-> (rd_n && wr_n && $past(!rd_n || !wr_n)));
endmodule

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_code;
    logic [15:0] fetch_addr;
    logic        dm_req, dm_wr, dm_wide;
    logic [15:0] dm_addr;
    logic [7:0]  dm_wdata, p2_reg, p0_in;
    logic        ale, psen_n, rd_n, wr_n, p0_oe, fetch_valid, rd_valid, dm_done;
    logic [7:0]  p0_out, p2_out, fetch_data, rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int bph;
    bit finished = 0;
    bit prev_fx = 0;
    logic [7:0] prev_fb = 8'h00;

    always #(CLK_P/2) clk = ~clk;

    xbus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ext_code(ext_code), .fetch_addr(fetch_addr),
        .dm_req(dm_req), .dm_wr(dm_wr), .dm_wide(dm_wide), .dm_addr(dm_addr),
        .dm_wdata(dm_wdata), .p2_reg(p2_reg), .p0_in(p0_in), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
        .p2_out(p2_out), .fetch_data(fetch_data), .fetch_valid(fetch_valid),
        .rd_data(rd_data), .rd_valid(rd_valid), .dm_done(dm_done)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s phase %0d: actual %0h expected %0h", req, what, bph, got, exp);
        end
    endtask

    // expected-value functions (k: 0 fetch, 1 read, 2 write)
    function automatic bit e_ale(int p, int k);
        return (p < 2) || (k == 0 && (p == 6 || p == 7));
    endfunction
    function automatic bit e_psen_n(int p, int k, bit ext);
        return !(k == 0 && ext && (p % 6) >= 3);
    endfunction
    function automatic bit e_ds_n(int p, int k, int want);
        return !(k == want && p >= 5 && p <= 10);
    endfunction
    function automatic bit e_oe(int p, int k, bit ext);
        if (k == 0) return ext && (p % 6) < 3;
        if (k == 1) return p < 5;
        return 1'b1;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        bph = (bph + 1) % 12;
    endtask

    task automatic do_cycle(input int k, input bit ext, input bit wide, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] p2r,
                            input logic [15:0] fa0, input logic [15:0] fa1,
                            input logic [7:0] fb0, input logic [7:0] fb1, input logic [7:0] rb);
        string rq;
        logic [15:0] fa;
        logic [7:0] ep0, ep2;
        bit efv;
        dm_req = (k != 0); dm_wr = (k == 2); dm_wide = wide; dm_addr = a;
        dm_wdata = wd; p2_reg = p2r; ext_code = ext; fetch_addr = fa0;
        for (int i = 0; i < 12; i++) begin
            step();
            fa = (bph < 6) ? fa0 : fa1;
            chk(k == 0 ? "R2" : "R4", "ale", ale, e_ale(bph, k));
            chk(k == 0 ? (ext ? "R3" : "R11") : "R4", "psen_n", psen_n, e_psen_n(bph, k, ext));
            chk("R5", "rd_n", rd_n, e_ds_n(bph, k, 1));
            chk("R5", "wr_n", wr_n, e_ds_n(bph, k, 2));
            rq = (k == 2) ? "R8" : ((k == 0 && !ext) ? "R11" : "R7");
            chk(rq, "p0_oe", p0_oe, e_oe(bph, k, ext));
            if (k == 0)      ep0 = fa[7:0];
            else if (k == 1) ep0 = a[7:0];
            else             ep0 = (bph < 3) ? a[7:0] : wd;
            if (e_oe(bph, k, ext)) chk(rq, "p0_out", p0_out, ep0);
            if (k == 0) ep2 = ext ? fa[15:8] : p2r;
            else        ep2 = wide ? a[15:8] : p2r;
            chk((k == 0 && !ext) ? "R11" : "R6", "p2_out", p2_out, ep2);
            efv = (bph == 0 && prev_fx) || (bph == 6 && k == 0 && ext);
            chk((k == 0 && !ext) ? "R11" : "R10", "fetch_valid", fetch_valid, efv);
            if (efv) chk("R10", "fetch_data", fetch_data, (bph == 0) ? prev_fb : fb0);
            chk("R9", "rd_valid", rd_valid, (bph == 11 && k == 1));
            if (bph == 11 && k == 1) chk("R9", "rd_data", rd_data, rb);
            chk("R9", "dm_done", dm_done, (bph == 11 && k != 0));
            if (k == 0)      p0_in = (bph < 6) ? fb0 : fb1;
            else if (k == 1) p0_in = rb;
            else             p0_in = 8'hA5;
            if (bph == 5) fetch_addr = fa1;
        end
        prev_fx = (k == 0) && ext;
        prev_fb = fb1;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ext_code = 1'b1; fetch_addr = '0; dm_req = 0; dm_wr = 0;
        dm_wide = 0; dm_addr = '0; dm_wdata = '0; p2_reg = '0; p0_in = '0;
        bph = 11;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ale", ale, 0);
        chk("R1", "psen_n", psen_n, 1);
        chk("R1", "rd_n", rd_n, 1);
        chk("R1", "wr_n", wr_n, 1);
        chk("R1", "p0_oe", p0_oe, 0);
        chk("R1", "valids", {fetch_valid, rd_valid, dm_done}, 0);
        rst_n = 1'b1;
        // directed corners
        do_cycle(0, 1, 0, 16'h0000, 8'h00, 8'h3C, 16'h1234, 16'h1235, 8'h11, 8'h22, 8'h00);
        do_cycle(1, 1, 1, 16'hBEEF, 8'h00, 8'h3C, 16'h1236, 16'h1237, 8'h00, 8'h00, 8'h5D);
        do_cycle(2, 1, 0, 16'hBE42, 8'hC7, 8'h3C, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00);
        do_cycle(1, 1, 0, 16'hFFFF, 8'h00, 8'h81, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'hFF);
        do_cycle(2, 0, 1, 16'h0000, 8'hFF, 8'h81, 16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00);
        do_cycle(0, 0, 0, 16'h0000, 8'h00, 8'h96, 16'hFFFF, 16'hFFFE, 8'h77, 8'h88, 8'h00);
        do_cycle(0, 1, 0, 16'h0000, 8'h00, 8'h96, 16'hFFFF, 16'h0000, 8'hFF, 8'h00, 8'h00);
        // constrained random
        void'($urandom(32'd4051));
        for (int n = 0; n < 80; n++) begin
            int r, k;
            r = $urandom % 4;
            k = (r < 2) ? 0 : r - 1;
            do_cycle(k, ($urandom % 5) != 0, $urandom % 2, 16'($urandom), 8'($urandom),
                     8'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
                     8'($urandom), 8'($urandom));
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule